// File: doc/BRIEF.md
# Framebuffer Control and Status Registers

This block is the small register file that sits beside a simple framebuffer controller. It answers byte-wide reads and writes inside a 32-byte window. The window holds:

- a control byte, whose top bit arms the vertical-sync interrupt;
- a status byte, which reports a fixed board identity together with a latched interrupt flag;
- a row of general-purpose byte registers. The display pipeline uses these for cursor and video settings.

The block counts no video timing itself. It takes a one-cycle vsync pulse from the timing generator and drives a level interrupt toward the host.

Reads are combinational from the address. Writes take effect on the clock edge on which the write strobe is high. Software clears an interrupt by writing any value to the status byte. A vsync that arrives in the same cycle as that clear wins, so no frame event is lost. The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore leaves reset two clock edges after the reset pin rises.

Top module: `fbreg_ctrl`

## Requirements
- R1: After reset, the control byte and every general byte read 0x00, the status byte reads 0x61, and `irq` is low.
- R2: The control byte at offset 0x10 stores all 8 written bits and reads them back unchanged.
- R3: A vsync pulse sets the pending flag (status bit 7) on that clock edge when the stored control bit 7 is 1. The status byte then reads 0xE1.
- R4: A vsync pulse has no effect while the stored control bit 7 is 0. This includes the cycle in which a write is setting that bit, because the enable is taken from the value held before the edge.
- R5: A write of any data to the status byte at offset 0x11 clears the pending flag. Status bits 6..0 are not writable and always read as 0x61.
- R6: When a vsync that would set pending and a status write occur in the same cycle, pending is set afterwards.
- R7: Offsets 0x12 to 0x1F are 14 independent read/write byte registers. Offsets 0x12, 0x13 and 0x14 carry cursor start, cursor end and video control.
- R8: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no register.
- R9: `irq` is high exactly when the pending flag is set. Pending holds until a status write clears it, even if the enable bit is later cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 5 | Byte offset inside the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| vsync | input | 1 | One-cycle frame-end pulse from display timing |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The assertions assume four things about the inputs:
- `addr` and `wdata` are stable around the sampling edge;
- `vsync` is a clean synchronous pulse;
- the two reset synchronizer stages have filled before any access is counted;
- a write lands on exactly one decoded target.

The stimulus changes every input on the falling clock edge and holds it for a full period. It waits out the synchronizer after releasing reset. It drives vsync only as single-cycle pulses, on its own or together with a control or status write, to reach the ordering corner cases.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;
  localparam int FB_ADDR_W   = 5;
  localparam int FB_DATA_W   = 8;
  localparam int FB_CTRL_OFF = 16;
  localparam int FB_STAT_OFF = 17;
  localparam int FB_GEN_BASE = 18;
  localparam int FB_IE_BIT   = 7;
  localparam int FB_PEND_BIT = 7;
  localparam logic [7:0] FB_STAT_ID = 8'h61;
endpackage

// File: rtl/fbreg_rst_sync.sv
module fbreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fbreg_decode.sv
module fbreg_decode #(
  parameter int ADDR_W   = 5,
  parameter int CTRL_OFF = 16,
  parameter int STAT_OFF = 17,
  parameter int GEN_BASE = 18,
  parameter int NGEN     = 14,
  parameter int IDX_W    = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_stat,
  output logic              hit_gen,
  output logic [IDX_W-1:0]  gen_idx,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic [NGEN-1:0]   gen_we
);
  always_comb begin
    hit_ctrl = (int'(addr) == CTRL_OFF);
    hit_stat = (int'(addr) == STAT_OFF);
    hit_gen  = (int'(addr) >= GEN_BASE) && (int'(addr) < GEN_BASE + NGEN);
    gen_idx  = IDX_W'(int'(addr) - GEN_BASE);
    wr_ctrl  = wr_en && hit_ctrl;
    wr_stat  = wr_en && hit_stat;
    for (int i = 0; i < NGEN; i++) begin
      gen_we[i] = wr_en && (int'(addr) == GEN_BASE + i);
    end
  end
endmodule

// File: rtl/fbreg_intr.sv
module fbreg_intr #(
  parameter int DATA_W   = 8,
  parameter int IE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vsync,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pend_q
);
  logic [DATA_W-1:0] ctrl_d;
  logic              pend_d;
  logic              frame_set;

  always_comb begin
    ctrl_d    = wr_ctrl ? wdata : ctrl_q;
    frame_set = vsync && ctrl_q[IE_BIT];
    if (frame_set)    pend_d = 1'b1;
    else if (wr_stat) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
    end
  end

  // R3 / R6: an enabled frame event always leaves pending set
  a_r3_vsync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && ctrl_q[IE_BIT]) |=> pend_q);
  // R4: a disabled frame event never raises a clear flag
  a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(vsync && ctrl_q[IE_BIT])) |=> !pend_q);
  // R5: a lone status write clears pending
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(vsync && ctrl_q[IE_BIT])) |=> !pend_q);
  // R9: pending holds without a clear or an enabled frame event
  a_r9_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !(vsync && ctrl_q[IE_BIT])) |=> $stable(pend_q));
  // R2: control captures the written byte
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/fbreg_gregs.sv
module fbreg_gregs #(
  parameter int DATA_W = 8,
  parameter int NGEN   = 14,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NGEN-1:0]   gen_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] byte_q [NGEN];
  logic [DATA_W-1:0] byte_d [NGEN];

  for (genvar g = 0; g < NGEN; g++) begin : g_byte
    always_comb byte_d[g] = gen_we[g] ? wdata : byte_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[g] <= '0;
      else        byte_q[g] <= byte_d[g];
    end

    // R7: a write lands in its own byte
    a_r7_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
      gen_we[g] |=> (byte_q[g] == $past(wdata)));
    // R7: a byte not written keeps its value
    a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_we[g] |=> $stable(byte_q[g]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NGEN; i++) begin
      if (int'(rd_idx) == i) rd_data = byte_q[i];
    end
  end
endmodule

// File: rtl/fbreg_ctrl.sv
module fbreg_ctrl
  import fbreg_pkg::*;
#(
  parameter int ADDR_W = FB_ADDR_W,
  parameter int DATA_W = FB_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              vsync,
  output logic              irq
);
  localparam int WIN_BYTES = 1 << ADDR_W;
  localparam int NGEN      = WIN_BYTES - FB_GEN_BASE;
  localparam int IDX_W     = $clog2(NGEN);

  logic              rst_s_n;
  logic              hit_ctrl, hit_stat, hit_gen;
  logic              wr_ctrl, wr_stat;
  logic [IDX_W-1:0]  gen_idx;
  logic [NGEN-1:0]   gen_we;
  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic [DATA_W-1:0] gen_rd;
  logic [DATA_W-1:0] stat_val;

  fbreg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  fbreg_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFF(FB_CTRL_OFF), .STAT_OFF(FB_STAT_OFF),
    .GEN_BASE(FB_GEN_BASE), .NGEN(NGEN), .IDX_W(IDX_W)
  ) u_dec (
    .wr_en(wr_en), .addr(addr), .hit_ctrl(hit_ctrl), .hit_stat(hit_stat),
    .hit_gen(hit_gen), .gen_idx(gen_idx), .wr_ctrl(wr_ctrl),
    .wr_stat(wr_stat), .gen_we(gen_we)
  );

  fbreg_intr #(.DATA_W(DATA_W), .IE_BIT(FB_IE_BIT)) u_intr (
    .clk(clk), .rst_n(rst_s_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(wdata), .vsync(vsync), .ctrl_q(ctrl_q), .pend_q(pend_q)
  );

  fbreg_gregs #(.DATA_W(DATA_W), .NGEN(NGEN), .IDX_W(IDX_W)) u_gen (
    .clk(clk), .rst_n(rst_s_n), .gen_we(gen_we), .wdata(wdata),
    .rd_idx(gen_idx), .rd_data(gen_rd)
  );

  always_comb begin
    stat_val              = DATA_W'(FB_STAT_ID);
    stat_val[FB_PEND_BIT] = pend_q;
    if (hit_ctrl)      rdata = ctrl_q;
    else if (hit_stat) rdata = stat_val;
    else if (hit_gen)  rdata = gen_rd;
    else               rdata = '0;
  end

  assign irq = pend_q;

  // R8: low half of the window reads zero
  a_r8_low_reads_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (int'(addr) < FB_CTRL_OFF) |-> (rdata == '0));
  // R8: at most one target decoded
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({hit_ctrl, hit_stat, hit_gen}));
  // R5: identity bits of status are fixed
  a_r5_status_id: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit_stat |-> (rdata[FB_PEND_BIT-1:0] == FB_STAT_ID[FB_PEND_BIT-1:0]));
  // R9: irq pin agrees with the status pending bit
  a_r9_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit_stat |-> (rdata[FB_PEND_BIT] == irq));
endmodule

// File: tb/test_fbreg_ctrl.sv
module test_fbreg_ctrl;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       vsync;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [32];
  logic       pend_m;

  fbreg_ctrl i_fbreg_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .vsync(vsync), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_at(input int a);
    if (a < 16)       return 8'h00;
    else if (a == 17) return {pend_m, 7'h61};
    else              return model[a];
  endfunction

  task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d, input logic vs);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = 5'(a);
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic sweep_all(input string tag);
    for (int a = 0; a < 32; a++) rd(a, expect_at(a), tag);
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; vsync = 1'b0;
    for (int a = 0; a < 32; a++) model[a] = 8'h00;
    pend_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    sweep_all("R1 reset read");
    check({7'h0, irq}, 8'h00, "R1 irq low after reset");

    // R7 R8 R2: two write patterns across the whole window
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 32; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + 11) ^ (p ? 8'hA5 : 8'h5A));
        if (a == 17) continue;
        cyc(1'b1, 5'(a), d, 1'b0);
        if (a >= 16) model[a] = d;
      end
      sweep_all(p ? "R7 R8 R2 pattern B" : "R7 R8 R2 pattern A");
    end

    // R2 control stores every byte value
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 5'd16, 8'(v), 1'b0);
      rd(16, 8'(v), "R2 control readback");
    end

    // R3 R4 R5: vsync under each control value, then clear
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 5'd16, 8'(v), 1'b0);
      cyc(1'b0, 5'd0, 8'h00, 1'b1);
      rd(17, v[7] ? 8'hE1 : 8'h61, v[7] ? "R3 vsync sets pending" : "R4 vsync ignored");
      check({7'h0, irq}, {7'h0, v[7]}, "R9 irq follows pending");
      cyc(1'b1, 5'd17, 8'(255 - v), 1'b0);
      rd(17, 8'h61, "R5 status write clears");
      check({7'h0, irq}, 8'h00, "R5 irq cleared");
    end
    model[16] = 8'hFF;

    // R4: enable written in the same cycle as vsync does not count
    cyc(1'b1, 5'd16, 8'h00, 1'b0);
    cyc(1'b1, 5'd16, 8'h80, 1'b1);
    rd(17, 8'h61, "R4 same-cycle enable write");

    // R6: vsync and status clear together
    cyc(1'b0, 5'd0, 8'h00, 1'b1);
    rd(17, 8'hE1, "R6 pending before race");
    cyc(1'b1, 5'd17, 8'h00, 1'b1);
    rd(17, 8'hE1, "R6 vsync wins over clear");
    check({7'h0, irq}, 8'h01, "R6 irq stays high");

    // R9: disabling does not drop pending
    cyc(1'b1, 5'd16, 8'h00, 1'b0);
    cyc(1'b0, 5'd0, 8'h00, 1'b1);
    rd(17, 8'hE1, "R9 pending held after disable");
    check({7'h0, irq}, 8'h01, "R9 irq held after disable");
    cyc(1'b1, 5'd17, 8'h80, 1'b0);
    rd(17, 8'h61, "R5 clear after hold");

    // R8: low-window write leaves all registers intact
    model[16] = 8'h00; pend_m = 1'b0;
    cyc(1'b1, 5'd4, 8'hFF, 1'b0);
    sweep_all("R8 writes ignored");

    // R1: reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 32; a++) model[a] = 8'h00;
    sweep_all("R1 second reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule